// File: doc/BRIEF.md
# Privileged Trap Entry Sequencer

This block owns the processor's privilege state and the switch from user mode to kernel mode. It watches the trap sources: an address fault, a page fault, a syscall, a timer preemption and an external interrupt. It also turns a privileged operation attempted from user mode into a trap of its own. When it accepts a trap, it runs a fixed sequence. First it raises the kernel mode bit. Then it captures the user program counter, stack pointer and four general-purpose registers into a save area. Next it loads the kernel stack pointer of the running task onto the stack-pointer bus. Last it steers the program counter to the handler address for the accepted cause. The core must not retire any instruction while this sequence runs.

The block is a companion to the core pipeline. The core presents its current architectural PC, SP and general-purpose values. It obeys the load strobes and the retire enable, and it raises the privileged-operation and return-from-trap requests it decodes. A return issued in kernel mode restores the saved context in one cycle and drops back to user mode at that same clock edge. Boot code runs in kernel mode out of reset and fills the handler table and the kernel stack pointer register.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the block is in kernel mode (`kernel_mode_o`=1), idle (`busy_o`=0, `retire_en_o`=1), with no load strobe raised and cause 0. The save area holds zeros.
- R2: A trap is accepted only when the block is idle and in user mode. At the accepting clock edge `kernel_mode_o` becomes 1 and `busy_o` becomes 1, before any register is saved.
- R3: After acceptance the sequence lasts exactly three cycles, with `retire_en_o`=0 throughout. In the first cycle the user state is captured. In the second, `sp_load_o`=1 with `sp_o` equal to the kernel stack pointer register. In the third, `pc_load_o`=1 with `pc_o` equal to the table entry for the latched cause.
- R4: While the sequence runs, no further trap is accepted and `cause_o` does not change, whatever requests are raised.
- R5: Cause codes are 0 address fault, 1 page fault, 2 privilege violation, 3 syscall, 4 timer, 5 external interrupt. When several requests are present together, the lowest code wins. The accepted code is held on `cause_o` until the next acceptance.
- R6: The save area captures `user_pc_i`, `user_sp_i` and the four 32-bit registers on `user_gpr_i` (register k in bits 32k+31:32k). Capture happens at the edge that ends the first sequence cycle.
- R7: A handler table write (`vec_wr_en_i`, 3-bit index, 32-bit data) takes effect only in kernel mode. In user mode it leaves the table unchanged.
- R8: A kernel stack pointer write (`ksp_wr_en_i`) takes effect only in kernel mode. In user mode it is ignored.
- R9: A privileged operation (`priv_op_i`) in idle kernel mode raises `priv_exec_o` in the same cycle. In user mode it never raises `priv_exec_o` and instead requests cause 2.
- R10: A return-from-trap (`rett_i`) in idle kernel mode raises `pc_load_o`, `sp_load_o` and `gpr_load_o` in the same cycle with the saved PC, SP and registers, and `kernel_mode_o` is 0 after that edge. In user mode it requests cause 2 instead.
- R11: Trap requests raised while in kernel mode are not accepted. They take effect only once the block is back in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_fault_i | input | 1 | Address fault request |
| page_fault_i | input | 1 | Page fault request |
| syscall_i | input | 1 | Syscall instruction request |
| timer_i | input | 1 | Timer preemption request |
| irq_i | input | 1 | External interrupt request |
| priv_op_i | input | 1 | Privileged operation (halt, I/O) decoded |
| rett_i | input | 1 | Return-from-trap decoded |
| user_pc_i | input | 32 | Current program counter |
| user_sp_i | input | 32 | Current stack pointer |
| user_gpr_i | input | 128 | Four general-purpose registers, packed |
| vec_wr_en_i | input | 1 | Handler table write enable |
| vec_wr_idx_i | input | 3 | Handler table write index |
| vec_wr_data_i | input | 32 | Handler table write data |
| ksp_wr_en_i | input | 1 | Kernel stack pointer register write enable |
| ksp_wr_data_i | input | 32 | Kernel stack pointer write data |
| kernel_mode_o | output | 1 | Mode bit, 1 = kernel |
| busy_o | output | 1 | Entry sequence in progress |
| retire_en_o | output | 1 | Core may retire instructions |
| priv_exec_o | output | 1 | Privileged operation may execute |
| cause_o | output | 3 | Latched trap cause |
| pc_load_o | output | 1 | Load `pc_o` into the PC |
| pc_o | output | 32 | PC value to load |
| sp_load_o | output | 1 | Load `sp_o` into the SP |
| sp_o | output | 32 | SP value to load |
| gpr_load_o | output | 1 | Load `gpr_o` into the registers |
| gpr_o | output | 128 | Register values to load |

## Verification
The hardest case to reach is a trap request that lands in the middle of an entry sequence. It has to arrive exactly one or two cycles after acceptance, while the block is already in kernel mode. The stimulus raises an interrupt and a timer request on the cycles right after a syscall is accepted, and holds them through the return. The cause must stay fixed, and the held requests must win only once user mode is restored. A second hard case is the user-mode writes to the handler table and the kernel stack pointer. These are checked through the target address and stack value of the next trap.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned CAUSE_W = 3;
  localparam int unsigned NUM_REQ = 6;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_ADDR    = 3'd0,
    CAUSE_PAGE    = 3'd1,
    CAUSE_PRIV    = 3'd2,
    CAUSE_SYSCALL = 3'd3,
    CAUSE_TIMER   = 3'd4,
    CAUSE_IRQ     = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAVE  = 2'd1,
    ST_STACK = 2'd2,
    ST_JUMP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int unsigned NREQ = 6,
  localparam int unsigned IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic [NREQ-1:0] req_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/trap_vector_table.sv
module trap_vector_table #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 32,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_idx_i == AW'(g))) entry_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = entry_q[rd_idx_i];
endmodule

// File: rtl/trap_save_area.sv
module trap_save_area #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NGPR = 4,
  localparam int unsigned GW = XLEN * NGPR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [GW-1:0]   gpr_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] sp_o,
  output logic [GW-1:0]   gpr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o  <= '0;
      sp_o  <= '0;
      gpr_o <= '0;
    end else if (cap_en_i) begin
      pc_o  <= pc_i;
      sp_o  <= sp_i;
      gpr_o <= gpr_i;
    end
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NGPR = 4,
  localparam int unsigned GW = XLEN * NGPR
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_fault_i,
  input  logic               page_fault_i,
  input  logic               syscall_i,
  input  logic               timer_i,
  input  logic               irq_i,
  input  logic               priv_op_i,
  input  logic               rett_i,
  input  logic [XLEN-1:0]    user_pc_i,
  input  logic [XLEN-1:0]    user_sp_i,
  input  logic [GW-1:0]      user_gpr_i,
  input  logic               vec_wr_en_i,
  input  logic [CAUSE_W-1:0] vec_wr_idx_i,
  input  logic [XLEN-1:0]    vec_wr_data_i,
  input  logic               ksp_wr_en_i,
  input  logic [XLEN-1:0]    ksp_wr_data_i,
  output logic               kernel_mode_o,
  output logic               busy_o,
  output logic               retire_en_o,
  output logic               priv_exec_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               pc_load_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               sp_load_o,
  output logic [XLEN-1:0]    sp_o,
  output logic               gpr_load_o,
  output logic [GW-1:0]      gpr_o
);
  seq_state_e         state_q, state_d;
  logic               mode_q, mode_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [XLEN-1:0]    ksp_q;

  logic               idle, user_priv, accept, ret_go;
  logic [NUM_REQ-1:0] req;
  logic               arb_valid;
  logic [CAUSE_W-1:0] arb_idx;
  logic [XLEN-1:0]    vec_rd;
  logic [XLEN-1:0]    sv_pc, sv_sp;
  logic [GW-1:0]      sv_gpr;

  assign idle      = (state_q == ST_IDLE);
  assign user_priv = !mode_q && (priv_op_i || rett_i);
  assign req       = {irq_i, timer_i, syscall_i, user_priv, page_fault_i, addr_fault_i};
  assign accept    = idle && !mode_q && arb_valid;
  assign ret_go    = idle && mode_q && rett_i;

  trap_arbiter #(.NREQ(NUM_REQ)) u_arb (
    .req_i   (req),
    .valid_o (arb_valid),
    .idx_o   (arb_idx)
  );

  trap_vector_table #(.AW(CAUSE_W), .DW(XLEN)) u_vec (
    .clk       (clk),
    .wr_en_i   (vec_wr_en_i && mode_q),
    .wr_idx_i  (vec_wr_idx_i),
    .wr_data_i (vec_wr_data_i),
    .rd_idx_i  (cause_q),
    .rd_data_o (vec_rd)
  );

  trap_save_area #(.XLEN(XLEN), .NGPR(NGPR)) u_save (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en_i (state_q == ST_SAVE),
    .pc_i     (user_pc_i),
    .sp_i     (user_sp_i),
    .gpr_i    (user_gpr_i),
    .pc_o     (sv_pc),
    .sp_o     (sv_sp),
    .gpr_o    (sv_gpr)
  );

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          mode_d  = 1'b1;
          cause_d = arb_idx;
          state_d = ST_SAVE;
        end else if (ret_go) begin
          mode_d = 1'b0;
        end
      end
      ST_SAVE:  state_d = ST_STACK;
      ST_STACK: state_d = ST_JUMP;
      ST_JUMP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b1;
      cause_q <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ksp_q <= '0;
    else if (ksp_wr_en_i && mode_q) ksp_q <= ksp_wr_data_i;
  end

  assign kernel_mode_o = mode_q;
  assign busy_o        = !idle;
  assign retire_en_o   = idle;
  assign priv_exec_o   = idle && mode_q && priv_op_i;
  assign cause_o       = cause_q;
  assign sp_load_o     = (state_q == ST_STACK) || ret_go;
  assign sp_o          = (state_q == ST_STACK) ? ksp_q : sv_sp;
  assign pc_load_o     = (state_q == ST_JUMP) || ret_go;
  assign pc_o          = (state_q == ST_JUMP) ? vec_rd : sv_pc;
  assign gpr_load_o    = ret_go;
  assign gpr_o         = sv_gpr;
endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
  parameter int unsigned CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          kernel_mode,
  input logic          busy,
  input logic          retire_en,
  input logic          priv_exec,
  input logic [CW-1:0] cause,
  input logic          pc_load,
  input logic          sp_load,
  input logic          gpr_load
);
  assert_mode_before_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> kernel_mode && !$past(kernel_mode));

  assert_stack_then_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sp_load) |=> (busy && pc_load && !sp_load));

  assert_no_retire_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !retire_en && !priv_exec);

  assert_cause_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cause));

  assert_user_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kernel_mode) |-> $past(pc_load && sp_load && gpr_load && !busy));

  assert_priv_kernel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    priv_exec |-> kernel_mode);
endmodule

bind trap_entry_seq trap_entry_checker #(.CW(trap_pkg::CAUSE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .kernel_mode (kernel_mode_o),
  .busy        (busy_o),
  .retire_en   (retire_en_o),
  .priv_exec   (priv_exec_o),
  .cause       (cause_o),
  .pc_load     (pc_load_o),
  .sp_load     (sp_load_o),
  .gpr_load    (gpr_load_o)
);

// File: tb/tb_trap_entry_seq.sv
`timescale 1ns/1ps
module tb_trap_entry_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic addr_f, page_f, sysc, tmr, irq, priv, rett;
  logic [31:0] upc, usp;
  logic [127:0] ugpr;
  logic vwe, kwe;
  logic [2:0] vidx;
  logic [31:0] vdat, kdat;
  logic kmode, busy, retire, pexec, pcl, spl, gprl;
  logic [2:0] cause;
  logic [31:0] pco, spo;
  logic [127:0] gpro;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          m_mode;
  int          m_step;
  int          m_cause;
  logic [31:0] m_vec [8];
  logic [31:0] m_ksp, m_spc, m_ssp;
  logic [127:0] m_sgpr;

  always #5 clk = ~clk;

  trap_entry_seq dut (
    .clk(clk), .rst_n(rst_n),
    .addr_fault_i(addr_f), .page_fault_i(page_f), .syscall_i(sysc),
    .timer_i(tmr), .irq_i(irq), .priv_op_i(priv), .rett_i(rett),
    .user_pc_i(upc), .user_sp_i(usp), .user_gpr_i(ugpr),
    .vec_wr_en_i(vwe), .vec_wr_idx_i(vidx), .vec_wr_data_i(vdat),
    .ksp_wr_en_i(kwe), .ksp_wr_data_i(kdat),
    .kernel_mode_o(kmode), .busy_o(busy), .retire_en_o(retire),
    .priv_exec_o(pexec), .cause_o(cause),
    .pc_load_o(pcl), .pc_o(pco), .sp_load_o(spl), .sp_o(spo),
    .gpr_load_o(gprl), .gpr_o(gpro)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit any_req();
    return addr_f | page_f | sysc | tmr | irq | ((priv | rett) & !m_mode);
  endfunction

  function automatic int pick();
    if (addr_f) return 0;
    if (page_f) return 1;
    if (priv | rett) return 2;
    if (sysc) return 3;
    if (tmr) return 4;
    return 5;
  endfunction

  task automatic compare();
    bit idle, ret;
    idle = (m_step == 0);
    ret  = idle && m_mode && rett;
    chk("R2/R11 kernel_mode", kmode, m_mode);
    chk("R3/R4 busy", busy, !idle);
    chk("R3 retire_en", retire, idle);
    chk("R9 priv_exec", pexec, idle && m_mode && priv);
    chk("R5/R4 cause", cause, m_cause);
    chk("R3/R10 sp_load", spl, (m_step == 2) || ret);
    chk("R3/R10 pc_load", pcl, (m_step == 3) || ret);
    chk("R10 gpr_load", gprl, ret);
    if (m_step == 2) chk("R3/R8 sp kernel stack", spo, m_ksp);
    if (m_step == 3) chk("R3/R7 pc handler", pco, m_vec[m_cause]);
    if (ret) begin
      chk("R10/R6 pc restore", pco, m_spc);
      chk("R10/R6 sp restore", spo, m_ssp);
      chk("R10/R6 gpr restore", gpro, m_sgpr);
    end
  endtask

  task automatic model_edge();
    case (m_step)
      0: begin
        if (m_mode) begin
          if (vwe) m_vec[vidx] = vdat;
          if (kwe) m_ksp = kdat;
          if (rett) m_mode = 0;
        end else if (any_req()) begin
          m_cause = pick();
          m_mode = 1;
          m_step = 1;
        end
      end
      1: begin
        if (vwe) m_vec[vidx] = vdat;
        if (kwe) m_ksp = kdat;
        m_spc = upc; m_ssp = usp; m_sgpr = ugpr; m_step = 2;
      end
      default: begin
        if (vwe) m_vec[vidx] = vdat;
        if (kwe) m_ksp = kdat;
        m_step = (m_step == 3) ? 0 : m_step + 1;
      end
    endcase
  endtask

  task automatic clear_in();
    addr_f = 0; page_f = 0; sysc = 0; tmr = 0; irq = 0; priv = 0; rett = 0;
    vwe = 0; kwe = 0; vidx = 0; vdat = 0; kdat = 0;
  endtask

  // one cycle: inputs already set at negedge
  task automatic step();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) begin clear_in(); step(); end
  endtask

  task automatic user_ctx(input logic [31:0] base);
    upc = base; usp = base + 32'h100;
    ugpr = {base ^ 32'h1111, base ^ 32'h2222, base ^ 32'h3333, base ^ 32'h4444};
  endtask

  // returns to user mode through a kernel-mode return
  task automatic go_user();
    clear_in(); rett = 1; step(); clear_in();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_in(); user_ctx(32'h1000);
    rst_n = 0;
    m_mode = 1; m_step = 0; m_cause = 0; m_ksp = 0; m_spc = 0; m_ssp = 0; m_sgpr = 0;
    for (int i = 0; i < 8; i++) m_vec[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    #1 compare();
    chk("R1 reset kernel", kmode, 1'b1);
    chk("R1 reset idle", busy, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // boot: fill handler table and kernel stack pointer (R7, R8)
    for (int i = 0; i < 8; i++) begin
      clear_in(); vwe = 1; vidx = 3'(i); vdat = 32'h8000_0000 + 32'(i) * 32'h40; step();
    end
    clear_in(); kwe = 1; kdat = 32'hC000_F000; step();
    // R9: privileged op in kernel executes
    clear_in(); priv = 1; step();
    // R10: first return restores reset-zero save area
    go_user();
    idle_n(2);

    // R7/R8: user-mode writes are ignored
    clear_in(); vwe = 1; vidx = 3'd3; vdat = 32'hDEAD_BEEF; step();
    clear_in(); kwe = 1; kdat = 32'h0BAD_0BAD; step();

    // syscall trap, with requests raised mid-sequence (R4) and held in kernel (R11)
    user_ctx(32'h2000);
    clear_in(); sysc = 1; step();
    clear_in(); irq = 1; step();
    clear_in(); irq = 1; tmr = 1; step();
    clear_in(); irq = 1; tmr = 1; step();
    clear_in(); irq = 1; tmr = 1; priv = 1; step();   // R9 in kernel, R11 held
    clear_in(); irq = 1; tmr = 1; rett = 1; step();   // R10 return
    clear_in(); irq = 1; tmr = 1; step();             // R11 timer wins now
    idle_n(4);
    go_user();

    // R5 priority cases
    user_ctx(32'h3000);
    clear_in(); addr_f = 1; page_f = 1; sysc = 1; tmr = 1; irq = 1; priv = 1; step();
    idle_n(4); go_user();
    clear_in(); page_f = 1; priv = 1; sysc = 1; step();
    idle_n(4); go_user();
    user_ctx(32'h4000);
    clear_in(); priv = 1; sysc = 1; tmr = 1; step();   // R9 user priv -> cause 2
    idle_n(4); go_user();
    clear_in(); sysc = 1; tmr = 1; irq = 1; step();
    idle_n(4); go_user();
    clear_in(); tmr = 1; irq = 1; step();
    idle_n(4);
    // kernel updates table and stack while in kernel (R7, R8)
    clear_in(); vwe = 1; vidx = 3'd5; vdat = 32'h9999_0000; step();
    clear_in(); kwe = 1; kdat = 32'hC111_0000; step();
    go_user();
    user_ctx(32'h5000);
    clear_in(); irq = 1; step();
    idle_n(4); go_user();
    clear_in(); rett = 1; step();                       // R10 user return -> cause 2
    idle_n(4);
    user_ctx(32'h6000);
    go_user();
    clear_in(); addr_f = 1; step();
    idle_n(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule